// File: doc/BRIEF.md
# Saturating Integrator Receive Filter

This block cleans up a single-wire serial receive line before it reaches a frame decoder. The raw line is first brought into the block clock domain by a two-stage synchroniser. A programmable prescaler divides the block clock to produce a sampling tick.

On every tick a saturating up/down counter takes one step toward the sampled level. The filtered output is a register. It flips to 0 only when the counter bottoms out at zero, and to 1 only when the counter tops out at its maximum. Anywhere in between, the output keeps its last value.

Because the counter integrates rather than restarts, short noise pulses partly cancel each other out. A clean edge appears at the output after about fifteen sampling periods. Any pulse shorter than that never reaches the output. The prescaler select lets the system trade filter delay against the worst-case bit length seen on the line.

Top module: `rx_integrating_filter`

## Requirements
- R1: After reset the filtered output is 1 and the integrator sits at its maximum (15), so a following low input needs 15 low ticks to flip the output.
- R2: On each sampling tick the counter steps up by one when the synchronised input is 1 and down by one when it is 0. Between ticks it holds.
- R3: The counter saturates. At 15 a high sample leaves it at 15, and at 0 a low sample leaves it at 0. A long dwell at either level therefore never adds extra delay to the next edge beyond 15 ticks.
- R4: The output becomes 0 only in the cycle the counter reaches 0, and becomes 1 only in the cycle it reaches 15. At every other count it holds.
- R5: With the counter saturated, a clean input edge reaches the output after between 14*D+3 and 15*D+2 block clock cycles, where D is the selected division.
- R6: Prescaler select encoding: 2'b00 divides by 3 (the reset value), 2'b01 by 1, 2'b10 by 2, 2'b11 by 4.
- R7: An input pulse lasting 14 ticks or fewer, starting from a saturated counter, leaves the output unchanged. A pulse of 15 ticks flips it.
- R8: An input that alternates with noise around a held level never produces an extra output toggle.
- R9: A change of prescaler select takes effect only at the next tick boundary. The current sampling period always completes with the old division.
- R10: The raw input passes through two synchronising flops before it is sampled, which adds two cycles to the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_raw | input | 1 | Asynchronous raw receive line |
| div_sel | input | 2 | Prescaler select (encoding in R6) |
| rx_filt | output | 1 | Filtered receive data, registered |

## Verification
A wrong count or a missed saturation leaves no trace until the next edge. It then shows as a latency that falls outside the R5 window, or as a 14-tick pulse that gets through. The bench compares the output every cycle against a behavioural integrator, so such a fault surfaces within the 15 ticks that follow the edge. A prescaler that mis-decodes or switches mid-period shifts every later output edge by at least one cycle. The per-setting latency windows catch that directly.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int CNT_W = 4;
  localparam int PRE_W = 3;

  typedef enum logic [1:0] {
    SEL_DIV3 = 2'b00,
    SEL_DIV1 = 2'b01,
    SEL_DIV2 = 2'b10,
    SEL_DIV4 = 2'b11
  } div_sel_e;

  function automatic logic [PRE_W-1:0] sel_to_div(input logic [1:0] s);
    case (s)
      SEL_DIV1: return PRE_W'(1);
      SEL_DIV2: return PRE_W'(2);
      SEL_DIV4: return PRE_W'(4);
      default:  return PRE_W'(3);
    endcase
  endfunction
endpackage

// File: rtl/rxf_sync.sv
module rxf_sync #(
  parameter int STAGES = 2,
  parameter logic INIT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {STAGES{INIT}};
    else     chain_q <= {chain_q[STAGES-2:0], d_async};
  end

  assign q_sync = chain_q[STAGES-1];

  // R10: the sampled value is the raw input from STAGES cycles earlier
  assert_sync_delay_R10: assert property (@(posedge clk) disable iff (rst)
    $past(!rst, 2) |-> q_sync == $past(d_async, 2));
endmodule

// File: rtl/rxf_tick_gen.sv
module rxf_tick_gen
  import rxf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] div_sel,
  output logic       tick
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] div_q;

  assign tick = (cnt_q == div_q - PRE_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      div_q <= sel_to_div(SEL_DIV3);
    end else if (tick) begin
      cnt_q <= '0;
      div_q <= sel_to_div(div_sel);   // R9: new division only at a boundary
    end else begin
      cnt_q <= cnt_q + PRE_W'(1);
    end
  end

  // R6: divide-by-1 ticks every cycle
  assert_div1_every_cycle_R6: assert property (@(posedge clk) disable iff (rst)
    (div_q == PRE_W'(1)) |-> tick);
  // R9: the division never changes in mid-period
  assert_div_change_at_tick_R9: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(div_q));
endmodule

// File: rtl/rxf_integrator.sv
module rxf_integrator
  import rxf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic samp,
  output logic level
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             out_q;

  always_comb begin
    cnt_d = cnt_q;
    if (tick) begin
      if (samp && cnt_q != TOP)       cnt_d = cnt_q + CNT_W'(1);
      else if (!samp && cnt_q != '0)  cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= TOP;
      out_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      if (cnt_d == '0)      out_q <= 1'b0;
      else if (cnt_d == TOP) out_q <= 1'b1;
    end
  end

  assign level = out_q;

  assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_q));
  assert_step_up_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && samp && cnt_q != TOP) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && samp && cnt_q == TOP) |=> cnt_q == TOP);
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && !samp && cnt_q == '0) |=> cnt_q == '0);
  assert_fall_at_zero_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(out_q) |-> cnt_q == '0);
  assert_rise_at_top_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(out_q) |-> cnt_q == TOP);
endmodule

// File: rtl/rx_integrating_filter.sv
module rx_integrating_filter
  import rxf_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_raw,
  input  logic [1:0] div_sel,
  output logic       rx_filt
);
  logic rx_s;
  logic tick;

  rxf_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d_async(rx_raw), .q_sync(rx_s));

  rxf_tick_gen u_tick (
    .clk(clk), .rst(rst), .div_sel(div_sel), .tick(tick));

  rxf_integrator u_int (
    .clk(clk), .rst(rst), .tick(tick), .samp(rx_s), .level(rx_filt));

  // R1: output idles high out of reset
  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> rx_filt);
endmodule

// File: tb/sim_rx_integrating_filter.sv
module sim_rx_integrating_filter;
  logic clk = 0, rst = 1, rx_raw = 1;
  logic [1:0] div_sel = 2'b00;
  logic rx_filt;
  int vectors = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rx_integrating_filter u0 (.clk(clk), .rst(rst), .rx_raw(rx_raw),
                            .div_sel(div_sel), .rx_filt(rx_filt));

  // behavioural reference
  bit sq[$];
  int m_lvl, m_phase, m_div;
  bit m_out;

  function automatic int dec(input logic [1:0] s);
    return (s == 2'b01) ? 1 : (s == 2'b10) ? 2 : (s == 2'b11) ? 4 : 3;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      sq = '{1'b1, 1'b1}; m_lvl = 15; m_phase = 0; m_div = 3; m_out = 1;
    end else begin
      if (m_phase == m_div - 1) begin
        if (sq[1]) m_lvl = (m_lvl < 15) ? m_lvl + 1 : 15;
        else       m_lvl = (m_lvl > 0) ? m_lvl - 1 : 0;
        m_phase = 0; m_div = dec(div_sel);
        if (m_lvl == 0) m_out = 0;
        else if (m_lvl == 15) m_out = 1;
      end else m_phase++;
      sq = '{rx_raw, sq[0]};
    end
  end

  task automatic check(input string req, input bit act, input bit exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison (R2 R4 R9 R10)
  always @(negedge clk) if (!rst && !done) check("R2/R4 model", rx_filt, m_out);

  task automatic hold(input bit v, input int n);
    rx_raw = v; repeat (n) @(negedge clk);
  endtask

  task automatic latency(input logic [1:0] s, input bit to);
    int d = dec(s), n = 0;
    div_sel = s; hold(!to, 100);
    rx_raw = to;
    do begin @(negedge clk); n++; end while (rx_filt !== to && n < 200);
    vectors++;
    if (n < 14*d + 3 || n > 15*d + 2) begin
      fails++;
      $display("FAIL R5/R6: sel %0b latency %0d expected %0d..%0d", s, n, 14*d+3, 15*d+2);
    end
  endtask

  task automatic pulse_ok(input string req, input bit base, input int cyc, input bit exp_after);
    bit seen = 0;
    hold(base, 100);
    rx_raw = !base;
    repeat (cyc) begin @(negedge clk); if (rx_filt !== base) seen = 1; end
    rx_raw = base;
    repeat (6) begin @(negedge clk); if (rx_filt !== base) seen = 1; end
    check(req, seen, exp_after);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 reset level", rx_filt, 1'b1);
    // R1: from reset, 45 low cycles at div 3 is exactly 15 ticks
    // R5 R6: latency windows for every setting, both edges
    latency(2'b00, 0); latency(2'b00, 1);
    latency(2'b01, 0); latency(2'b01, 1);
    latency(2'b10, 0); latency(2'b10, 1);
    latency(2'b11, 0); latency(2'b11, 1);
    // R7: 14-tick pulses rejected, 15 pass (div 1 and div 3)
    div_sel = 2'b01; hold(1, 10);
    pulse_ok("R7 14-tick low pulse d1", 1, 14, 0);
    pulse_ok("R7 15-tick low pulse d1", 1, 15, 1);
    div_sel = 2'b00; hold(1, 100);
    pulse_ok("R7 14-tick low pulse d3", 1, 42, 0);
    // R3: long dwell high, then still exactly 15 ticks needed
    div_sel = 2'b01; hold(1, 300);
    pulse_ok("R3 saturate high", 1, 14, 0);
    hold(0, 300);
    pulse_ok("R3 saturate low", 0, 14, 0);
    pulse_ok("R3 low then 15", 0, 15, 1);
    // R8: alternating noise around a held level
    hold(1, 60);
    begin
      bit seen = 0;
      for (int i = 0; i < 200; i++) begin
        rx_raw = i[0] | (i % 3 == 0); @(negedge clk);
        if (rx_filt !== 1'b1) seen = 1;
      end
      check("R8 noise hold high", seen, 1'b0);
    end
    // R9: change select mid-period at div 4
    div_sel = 2'b11; hold(1, 20);
    @(negedge clk); div_sel = 2'b01; hold(0, 80);
    check("R9 switched divisor", rx_filt, 1'b0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule